// File: doc/BRIEF.md
# Split Byte-Wide Program Counter

This block holds the 16-bit instruction address of a byte-oriented processor as two independent byte registers. Sequential fetch bumps the low byte through its own incrementer. Only the carry from that incrementer makes the high byte count up, so the address crosses a 256-byte page boundary in the same cycle as the wrap.

An absolute jump writes the two bytes from the 8-bit internal bus on two separate cycles, one after the other. For a relative branch, the low byte is steered onto an ALU operand. The ALU sum comes back as a low-byte writeback. When the branch leaves the current page, a separate request moves the high byte one step up or down.

Decode, memory and the ALU sit outside the block.

Top module: `pc_split_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter takes `rst_vec_hi` as its high byte and `rst_vec_lo` as its low byte.
- R2: With `inc_en` high and no low-byte load or branch writeback, the low byte becomes its old value plus one, modulo 256, at the next edge.
- R3: `lo_carry` is high exactly when the low byte increments from 0xFF. At that edge the low byte becomes 0x00 and the high byte becomes its old value plus one, unless a high-byte load or fix-up is also requested.
- R4: With no carry, no `ld_hi` and no `fix_up`, the high byte keeps its value.
- R5: `ld_lo` writes `bus_in` into the low byte, and `ld_hi` writes `bus_in` into the high byte. Each load changes only its own byte, so two consecutive loads form a full jump target.
- R6: A load has priority over every other update of the same byte. When `ld_lo` and `inc_en` are both high, the low byte takes `bus_in`, `lo_carry` stays low and the high byte does not count.
- R7: `br_wr` without `ld_lo` writes `br_val` into the low byte and overrides `inc_en`. No carry is produced, so the high byte is not touched by the writeback.
- R8: `fix_up` without `ld_hi` sets the high byte to its old value plus one when `fix_dir` is 1, or minus one when `fix_dir` is 0, modulo 256. A fix-up takes priority over a simultaneous low-byte carry, so the carry is discarded.
- R9: `alu_a` equals the low byte while `alu_route` is 1, and equals 0x00 while it is 0.
- R10: `pc_full` is the high byte in bits 15:8 and the low byte in bits 7:0. Incrementing from 0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_vec_lo | input | 8 | Low byte taken during reset |
| rst_vec_hi | input | 8 | High byte taken during reset |
| inc_en | input | 1 | Sequential increment request |
| ld_lo | input | 1 | Load low byte from the bus |
| ld_hi | input | 1 | Load high byte from the bus |
| bus_in | input | 8 | Internal data bus |
| br_wr | input | 1 | Branch result writeback to the low byte |
| br_val | input | 8 | Branch result from the ALU |
| fix_up | input | 1 | Page-crossing adjust of the high byte |
| fix_dir | input | 1 | Adjust direction: 1 adds, 0 subtracts |
| alu_route | input | 1 | Steer the low byte onto the ALU operand |
| pc_lo | output | 8 | Low byte |
| pc_hi | output | 8 | High byte |
| pc_full | output | 16 | Concatenated address |
| lo_carry | output | 1 | Carry out of the low-byte incrementer |
| alu_a | output | 8 | ALU operand from the low byte |

## Verification
The properties assume that every control input holds a known 0 or 1 level from the first edge after reset. They also assume that `bus_in`, `br_val` and `fix_dir` are valid in any cycle where the request that uses them is high. The bench drives all inputs one time unit after a rising edge and holds them for the whole cycle, so nothing changes near a sampling edge. The bench also deliberately raises conflicting requests together (load with increment, writeback with increment, fix-up with carry, load with fix-up) so that the priority properties see their antecedents.

// File: rtl/pc_split_pkg.sv
package pc_split_pkg;

  // Selection of the next low-byte value, in ascending priority.
  typedef enum logic [1:0] {
    LO_KEEP   = 2'd0,
    LO_STEP   = 2'd1,
    LO_BRANCH = 2'd2,
    LO_LOAD   = 2'd3
  } lo_sel_e;

  // Selection of the next high-byte value, in ascending priority.
  typedef enum logic [1:0] {
    HI_KEEP  = 2'd0,
    HI_CARRY = 2'd1,
    HI_FIX   = 2'd2,
    HI_LOAD  = 2'd3
  } hi_sel_e;

endpackage

// File: rtl/pc_lo_byte.sv
module pc_lo_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         br,
  input  logic [W-1:0] br_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         carry
);
  import pc_split_pkg::*;

  // Incrementer with the carry brought out as the top bit.
  function automatic logic [W:0] widen_inc(input logic [W-1:0] v);
    widen_inc = {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  lo_sel_e      sel;
  logic [W:0]   inc_res;

  always_comb begin
    if (ld)       sel = LO_LOAD;
    else if (br)  sel = LO_BRANCH;
    else if (inc) sel = LO_STEP;
    else          sel = LO_KEEP;
  end

  assign inc_res = widen_inc(q);
  assign carry   = (sel == LO_STEP) && inc_res[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= rst_val;
    end else begin
      unique case (sel)
        LO_LOAD:   q <= ld_val;
        LO_BRANCH: q <= br_val;
        LO_STEP:   q <= inc_res[W-1:0];
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/pc_hi_byte.sv
module pc_hi_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         fix,
  input  logic         fix_up_dir,
  input  logic         carry_in,
  output logic [W-1:0] q
);
  import pc_split_pkg::*;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // One step up or down, wrapping modulo 2**W.
  function automatic logic [W-1:0] step_byte(input logic [W-1:0] v, input logic up);
    step_byte = up ? (v + ONE) : (v - ONE);
  endfunction

  hi_sel_e sel;

  always_comb begin
    if (ld)            sel = HI_LOAD;
    else if (fix)      sel = HI_FIX;
    else if (carry_in) sel = HI_CARRY;
    else               sel = HI_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= rst_val;
    end else begin
      unique case (sel)
        HI_LOAD:  q <= ld_val;
        HI_FIX:   q <= step_byte(q, fix_up_dir);
        HI_CARRY: q <= step_byte(q, 1'b1);
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/pc_alu_tap.sv
module pc_alu_tap #(
  parameter int W = 8
) (
  input  logic         route,
  input  logic [W-1:0] lo_byte,
  output logic [W-1:0] operand
);
  assign operand = route ? lo_byte : '0;
endmodule

// File: rtl/pc_split_counter.sv
module pc_split_counter #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   rst_vec_lo,
  input  logic [W-1:0]   rst_vec_hi,
  input  logic           inc_en,
  input  logic           ld_lo,
  input  logic           ld_hi,
  input  logic [W-1:0]   bus_in,
  input  logic           br_wr,
  input  logic [W-1:0]   br_val,
  input  logic           fix_up,
  input  logic           fix_dir,
  input  logic           alu_route,
  output logic [W-1:0]   pc_lo,
  output logic [W-1:0]   pc_hi,
  output logic [2*W-1:0] pc_full,
  output logic           lo_carry,
  output logic [W-1:0]   alu_a
);
  // Named carry wire between the two byte halves.
  logic lo_wrap_carry;

  pc_lo_byte #(.W(W)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (rst_vec_lo),
    .ld      (ld_lo),
    .ld_val  (bus_in),
    .br      (br_wr),
    .br_val  (br_val),
    .inc     (inc_en),
    .q       (pc_lo),
    .carry   (lo_wrap_carry)
  );

  pc_hi_byte #(.W(W)) u_hi (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_val    (rst_vec_hi),
    .ld         (ld_hi),
    .ld_val     (bus_in),
    .fix        (fix_up),
    .fix_up_dir (fix_dir),
    .carry_in   (lo_wrap_carry),
    .q          (pc_hi)
  );

  pc_alu_tap #(.W(W)) u_tap (
    .route   (alu_route),
    .lo_byte (pc_lo),
    .operand (alu_a)
  );

  assign lo_carry = lo_wrap_carry;
  assign pc_full  = {pc_hi, pc_lo};
endmodule

// File: rtl/pc_split_counter_chk.sv
module pc_split_counter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inc_en,
  input logic         ld_lo,
  input logic         ld_hi,
  input logic [W-1:0] bus_in,
  input logic         br_wr,
  input logic [W-1:0] br_val,
  input logic         fix_up,
  input logic         fix_dir,
  input logic         alu_route,
  input logic [W-1:0] pc_lo,
  input logic [W-1:0] pc_hi,
  input logic         lo_carry,
  input logic [W-1:0] alu_a
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assert_lo_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ld_lo && !br_wr) |=> (pc_lo == ($past(pc_lo) + ONE)));

  assert_carry_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_carry |-> (inc_en && !ld_lo && !br_wr && (pc_lo == {W{1'b1}})));

  assert_carry_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_carry && !ld_hi && !fix_up) |=> (pc_hi == ($past(pc_hi) + ONE)));

  assert_hi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_carry && !ld_hi && !fix_up) |=> $stable(pc_hi));

  assert_ld_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (pc_lo == $past(bus_in)));

  assert_ld_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> (pc_hi == $past(bus_in)));

  assert_ld_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |-> !lo_carry);

  assert_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_wr && !ld_lo) |=> (pc_lo == $past(br_val)));

  assert_fix_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_up && !ld_hi) |=>
      (pc_hi == ($past(fix_dir) ? ($past(pc_hi) + ONE) : ($past(pc_hi) - ONE))));

  assert_alu_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_route |-> (alu_a == '0));
endmodule

bind pc_split_counter pc_split_counter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inc_en    (inc_en),
  .ld_lo     (ld_lo),
  .ld_hi     (ld_hi),
  .bus_in    (bus_in),
  .br_wr     (br_wr),
  .br_val    (br_val),
  .fix_up    (fix_up),
  .fix_dir   (fix_dir),
  .alu_route (alu_route),
  .pc_lo     (pc_lo),
  .pc_hi     (pc_hi),
  .lo_carry  (lo_carry),
  .alu_a     (alu_a)
);

// File: tb/pc_split_counter_test.sv
module pc_split_counter_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rst_vec_lo, rst_vec_hi, bus_in, br_val;
  logic        inc_en, ld_lo, ld_hi, br_wr, fix_up, fix_dir, alu_route;
  logic [7:0]  pc_lo, pc_hi, alu_a;
  logic [15:0] pc_full;
  logic        lo_carry;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pc_split_counter uut (
    .clk(clk), .rst_n(rst_n), .rst_vec_lo(rst_vec_lo), .rst_vec_hi(rst_vec_hi),
    .inc_en(inc_en), .ld_lo(ld_lo), .ld_hi(ld_hi), .bus_in(bus_in),
    .br_wr(br_wr), .br_val(br_val), .fix_up(fix_up), .fix_dir(fix_dir),
    .alu_route(alu_route), .pc_lo(pc_lo), .pc_hi(pc_hi), .pc_full(pc_full),
    .lo_carry(lo_carry), .alu_a(alu_a)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle();
    inc_en = 0; ld_lo = 0; ld_hi = 0; br_wr = 0; fix_up = 0; fix_dir = 0;
    alu_route = 0; bus_in = 8'h00; br_val = 8'h00;
  endtask

  // Inputs change one unit after an edge; outputs are read at the same point.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_pc(input logic [15:0] v);
    idle(); ld_lo = 1; bus_in = v[7:0]; tick();
    idle(); ld_hi = 1; bus_in = v[15:8]; tick();
    idle();
  endtask

  task automatic t_reset();
    idle(); rst_n = 0; rst_vec_lo = 8'hFE; rst_vec_hi = 8'h12; tick();
    chk("R1 reset value", {pc_hi, pc_lo}, 16'h12FE);
    rst_n = 1;
  endtask

  task automatic t_increment();
    inc_en = 1; tick();
    chk("R2 low step", pc_full, 16'h12FF);
    chk("R3 carry flagged at 0xFF", {15'd0, lo_carry}, 16'd1);
    tick();
    chk("R3 page cross", pc_full, 16'h1300);
    inc_en = 0; tick();
    chk("R4 high holds when idle", pc_full, 16'h1300);
    inc_en = 1; tick(); tick();
    chk("R4 high holds without carry", pc_full, 16'h1302);
    idle();
  endtask

  task automatic t_jump();
    ld_lo = 1; bus_in = 8'h34; tick();
    chk("R5 low load only", pc_full, 16'h1334);
    idle(); ld_hi = 1; bus_in = 8'hAB; tick();
    chk("R5 high load completes jump", pc_full, 16'hAB34);
    chk("R10 concatenation", {pc_hi, pc_lo}, pc_full);
    idle();
  endtask

  task automatic t_priority();
    set_pc(16'hABFF);
    ld_lo = 1; inc_en = 1; bus_in = 8'h10; #1;
    chk("R6 no carry while loading", {15'd0, lo_carry}, 16'd0);
    tick();
    chk("R6 load beats increment", pc_full, 16'hAB10);
    idle(); ld_hi = 1; fix_up = 1; fix_dir = 1; bus_in = 8'h40; tick();
    chk("R8 high load beats fix-up", pc_full, 16'h4010);
    idle();
  endtask

  task automatic t_branch();
    set_pc(16'h40FF);
    br_wr = 1; br_val = 8'h80; inc_en = 1; tick();
    chk("R7 branch writeback, no carry", pc_full, 16'h4080);
    idle(); ld_lo = 1; br_wr = 1; bus_in = 8'h11; br_val = 8'h22; tick();
    chk("R7 load beats writeback", pc_full, 16'h4011);
    idle();
  endtask

  task automatic t_fixup();
    set_pc(16'h4080);
    fix_up = 1; fix_dir = 1; tick();
    chk("R8 fix-up adds one", pc_full, 16'h4180);
    fix_dir = 0; tick(); tick();
    chk("R8 fix-up subtracts one", pc_full, 16'h3F80);
    idle(); set_pc(16'h0080);
    fix_up = 1; fix_dir = 0; tick();
    chk("R8 fix-up wraps down", pc_full, 16'hFF80);
    idle(); set_pc(16'h20FF);
    inc_en = 1; fix_up = 1; fix_dir = 0; tick();
    chk("R8 fix-up overrides carry", pc_full, 16'h1F00);
    idle();
  endtask

  task automatic t_wrap();
    set_pc(16'hFFFF);
    inc_en = 1; tick();
    chk("R10 full wrap", pc_full, 16'h0000);
    idle();
  endtask

  task automatic t_alu();
    set_pc(16'h5A7C);
    alu_route = 1; #1;
    chk("R9 routed operand", {8'h00, alu_a}, 16'h007C);
    alu_route = 0; #1;
    chk("R9 idle operand", {8'h00, alu_a}, 16'h0000);
    idle();
  endtask

  initial begin
    #(CLK_P * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; rst_vec_lo = 8'h00; rst_vec_hi = 8'h00;
    idle();
    #1;
    t_reset();
    t_increment();
    t_jump();
    t_priority();
    t_branch();
    t_fixup();
    t_wrap();
    t_alu();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule